// File: doc/BRIEF.md
# Dual Wiper SPI Command Decoder

This block is the serial front end of a two-channel digital potentiometer. It takes a mode-0 style SPI stream (SI captured on rising SCK, SO launched on falling SCK) together with chip select, a pause input and two board-strapped address pins. The SPI inputs are treated as already synchronous to the system clock `clk_i`. SCK is oversampled, so every SCK half period must last at least two system clocks.

Each transaction opens with an identification byte that names the device type and the bus address. The second byte carries an opcode, a data-register index and a pot index. Depending on the opcode, the block does one of four things:
- it ends the transaction after a register transfer,
- it runs a third byte that reads or writes a value,
- it enters an open-ended stepping mode that lasts until chip select rises,
- it ignores the rest of the transaction.

Actions reach the wiper registers and the data-register bank as one-clock strobes with data. The bank and the wiper registers live outside this block and return their current contents on `wcr_i` and `dr_rdata_i`.

Top module: `dpot_spi_decoder`

## Requirements
- R1: SI is captured only on a rising SCK. so_o changes only in the clock after a falling SCK is seen or after CS goes high. so_oe_o is 1 exactly while cs_ni is 0.
- R2: The first byte after a CS falling edge must be 0101 in bits 7:4, 00 in bits 3:2 and equal to addr_i in bits 1:0. Any other value causes every later byte to be ignored until CS rises.
- R3: After reset, no byte is decoded until a high-to-low transition of cs_ni has been seen, even if cs_ni is already low when reset ends.
- R4: The second byte is decoded as opcode = bits 7:4, data-register index = bits 3:2, pot index = bit 0. The index drives dr_sel_o.
- R5: Opcode 0x8 writes the selected data register of the selected pot into that pot's wiper. Opcode 0x6 writes the selected pot's wiper into its selected data register. Both end the command after the second byte.
- R6: Opcode 0x1 loads both wipers from their selected data registers. Opcode 0x2 stores both wipers into their selected data registers. Each produces a single strobe covering both pots.
- R7: Opcode 0xA writes the low 6 bits of the third byte to the selected wiper. Opcode 0xC writes them to the selected data register.
- R8: On the third byte, opcodes 0x9, 0xB and 0x5 return, MSB first, the selected wiper, the selected data register, or wip_i in bit 0. Unused upper bits are 0.
- R9: Opcode 0x3 enters stepping mode. Every later rising SCK emits one step strobe for the selected pot, with wcr_up_o equal to SI. The mode lasts until CS rises.
- R10: hold_ni falling while SCK is low pauses the interface, and SCK edges during the pause are ignored. hold_ni rising while SCK is low resumes it with the bit position kept.
- R11: Opcodes 0x0, 0x4, 0x7 and 0xD to 0xF produce no strobe.
- R12: Every strobe lasts one clock. Only one of the wiper-write, step and register-write kinds is active in a cycle. No strobe follows a cycle with cs_ni high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock, synchronous to clk_i |
| cs_ni | input | 1 | Chip select, active low |
| si_i | input | 1 | Serial data in |
| hold_ni | input | 1 | Pause request, active low |
| addr_i | input | 2 | Strapped bus address |
| wip_i | input | 1 | Nonvolatile write busy flag, returned by status read |
| wcr_i | input | 2*DW | Current wiper values, pot 1 in the upper slice |
| dr_rdata_i | input | 2*DW | Data register at dr_sel_o for each pot |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for so_o |
| wcr_we_o | output | 2 | Wiper write strobe per pot |
| wcr_wdata_o | output | 2*DW | Wiper write data per pot |
| wcr_step_o | output | 2 | Wiper step strobe per pot |
| wcr_up_o | output | 1 | Step direction, 1 = up |
| dr_we_o | output | 2 | Data register write strobe per pot |
| dr_sel_o | output | 2 | Data register index |
| dr_wdata_o | output | 2*DW | Data register write data per pot |

## Verification
On every cycle, the checker confirms that so_o holds still unless a falling SCK or a deselect came before it. It also confirms that strobes are single-cycle, never mix kinds, never name both pots in stepping, and stay quiet after a deselected cycle.

Only the bench scenarios can show the following:
- that a bad address, a bad type code or a nonzero reserved field suppresses a command;
- that the block waits for a first CS falling edge after reset;
- that transfers pick the right register and pot;
- that read bytes arrive MSB first;
- that a pause keeps the bit position across ignored SCK pulses.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
  localparam int NPOT   = 2;
  localparam int BYTE_W = 8;
  localparam int RSEL_W = 2;

  typedef enum logic [3:0] {
    OP_GXFR_D2W = 4'h1,
    OP_GXFR_W2D = 4'h2,
    OP_STEP     = 4'h3,
    OP_RD_STAT  = 4'h5,
    OP_XFR_W2D  = 4'h6,
    OP_XFR_D2W  = 4'h8,
    OP_RD_WCR   = 4'h9,
    OP_WR_WCR   = 4'hA,
    OP_RD_DR    = 4'hB,
    OP_WR_DR    = 4'hC
  } opcode_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ID, ST_INSTR, ST_EXEC, ST_DATA, ST_STEP, ST_SKIP
  } state_e;
endpackage

// File: rtl/dpot_spi_phy.sv
module dpot_spi_phy
  import dpot_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              cs_ni,
  input  logic              si_i,
  input  logic              hold_ni,
  input  logic              tx_load_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  input  logic              tx_en_i,
  output logic              start_o,
  output logic              active_o,
  output logic              rise_o,
  output logic              bit_o,
  output logic              byte_vld_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              so_o
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic              sck_q, cs_q, paused_q, so_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-2:0] rx_q;
  logic [BYTE_W-1:0] tx_q;
  logic              fall;

  assign active_o   = !cs_ni;
  // cs_q resets low so a select already low at reset is not taken as an edge
  assign start_o    = cs_q && !cs_ni;
  assign rise_o     = active_o && !paused_q && sck_i && !sck_q;
  assign fall       = active_o && !paused_q && !sck_i && sck_q;
  assign bit_o      = si_i;
  assign byte_vld_o = rise_o && (cnt_q == CNT_W'(BYTE_W - 1));
  assign byte_o     = {rx_q, si_i};
  assign so_o       = so_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q    <= 1'b0;
      cs_q     <= 1'b0;
      paused_q <= 1'b0;
      cnt_q    <= '0;
      rx_q     <= '0;
      tx_q     <= '0;
      so_q     <= 1'b0;
    end else begin
      sck_q <= sck_i;
      cs_q  <= cs_ni;
      if (cs_ni) begin
        paused_q <= 1'b0;
        cnt_q    <= '0;
        so_q     <= 1'b0;
      end else begin
        if (!sck_i) paused_q <= !hold_ni;
        if (start_o) cnt_q <= '0;
        else if (rise_o) begin
          cnt_q <= cnt_q + 1'b1;
          rx_q  <= {rx_q[BYTE_W-3:0], si_i};
        end
        if (tx_load_i) tx_q <= tx_byte_i;
        else if (fall && tx_en_i) begin
          so_q <= tx_q[BYTE_W-1];
          tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/dpot_cmd_fsm.sv
module dpot_cmd_fsm
  import dpot_pkg::*;
#(
  parameter int         DW      = 6,
  parameter logic [3:0] TYPE_ID = 4'b0101
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               active_i,
  input  logic               rise_i,
  input  logic               bit_i,
  input  logic               byte_vld_i,
  input  logic [BYTE_W-1:0]  byte_i,
  input  logic [1:0]         addr_i,
  input  logic               wip_i,
  input  logic [NPOT*DW-1:0] wcr_i,
  input  logic [NPOT*DW-1:0] dr_rdata_i,
  output logic               tx_load_o,
  output logic [BYTE_W-1:0]  tx_byte_o,
  output logic               tx_en_o,
  output logic [NPOT-1:0]    wcr_we_o,
  output logic [NPOT*DW-1:0] wcr_wdata_o,
  output logic [NPOT-1:0]    wcr_step_o,
  output logic               wcr_up_o,
  output logic [NPOT-1:0]    dr_we_o,
  output logic [RSEL_W-1:0]  dr_sel_o,
  output logic [NPOT*DW-1:0] dr_wdata_o
);
  state_e            state_q, state_d;
  opcode_e           op_q;
  logic [RSEL_W-1:0] reg_q;
  logic              pot_q, glob, is_read, id_ok;
  logic [NPOT-1:0]   hit;
  logic [DW-1:0]     wcr_a [NPOT];
  logic [DW-1:0]     dr_a  [NPOT];

  assign glob = (op_q == OP_GXFR_D2W) || (op_q == OP_GXFR_W2D);

  for (genvar g = 0; g < NPOT; g++) begin : g_pot
    assign wcr_a[g] = wcr_i[g*DW +: DW];
    assign dr_a[g]  = dr_rdata_i[g*DW +: DW];
    assign hit[g]   = glob || (pot_q == 1'(g));
  end

  assign is_read  = (op_q == OP_RD_WCR) || (op_q == OP_RD_DR) || (op_q == OP_RD_STAT);
  assign id_ok    = (byte_i[7:4] == TYPE_ID) && (byte_i[3:2] == 2'b00) && (byte_i[1:0] == addr_i);
  assign dr_sel_o = reg_q;
  assign tx_en_o  = (state_q == ST_DATA) && is_read;
  assign tx_load_o = active_i && (state_q == ST_EXEC) && is_read;

  always_comb begin
    case (op_q)
      OP_RD_WCR: tx_byte_o = BYTE_W'(wcr_a[pot_q]);
      OP_RD_DR:  tx_byte_o = BYTE_W'(dr_a[pot_q]);
      default:   tx_byte_o = BYTE_W'(wip_i);
    endcase
  end

  always_comb begin
    state_d = state_q;
    if (!active_i) state_d = ST_IDLE;
    else begin
      case (state_q)
        ST_IDLE:  if (start_i) state_d = ST_ID;
        ST_ID:    if (byte_vld_i) state_d = id_ok ? ST_INSTR : ST_SKIP;
        ST_INSTR: if (byte_vld_i) state_d = ST_EXEC;
        ST_EXEC: begin
          case (op_q)
            OP_RD_WCR, OP_RD_DR, OP_RD_STAT,
            OP_WR_WCR, OP_WR_DR: state_d = ST_DATA;
            OP_STEP:             state_d = ST_STEP;
            default:             state_d = ST_SKIP;
          endcase
        end
        ST_DATA:  if (byte_vld_i) state_d = ST_SKIP;
        default:  state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      op_q        <= OP_GXFR_D2W;
      reg_q       <= '0;
      pot_q       <= 1'b0;
      wcr_we_o    <= '0;
      wcr_step_o  <= '0;
      wcr_up_o    <= 1'b0;
      dr_we_o     <= '0;
      wcr_wdata_o <= '0;
      dr_wdata_o  <= '0;
    end else begin
      state_q    <= state_d;
      wcr_we_o   <= '0;
      wcr_step_o <= '0;
      dr_we_o    <= '0;
      if (active_i) begin
        case (state_q)
          ST_INSTR: if (byte_vld_i) begin
            op_q  <= opcode_e'(byte_i[7:4]);
            reg_q <= byte_i[3:2];
            pot_q <= byte_i[0];
          end
          ST_EXEC: begin
            if (op_q == OP_XFR_D2W || op_q == OP_GXFR_D2W) begin
              wcr_we_o    <= hit;
              wcr_wdata_o <= dr_rdata_i;
            end else if (op_q == OP_XFR_W2D || op_q == OP_GXFR_W2D) begin
              dr_we_o    <= hit;
              dr_wdata_o <= wcr_i;
            end
          end
          ST_DATA: if (byte_vld_i) begin
            if (op_q == OP_WR_WCR) begin
              wcr_we_o    <= hit;
              wcr_wdata_o <= {NPOT{byte_i[DW-1:0]}};
            end else if (op_q == OP_WR_DR) begin
              dr_we_o    <= hit;
              dr_wdata_o <= {NPOT{byte_i[DW-1:0]}};
            end
          end
          ST_STEP: if (rise_i) begin
            wcr_step_o <= hit;
            wcr_up_o   <= bit_i;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dpot_spi_decoder.sv
module dpot_spi_decoder
  import dpot_pkg::*;
#(
  parameter int         DW      = 6,
  parameter logic [3:0] TYPE_ID = 4'b0101
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sck_i,
  input  logic               cs_ni,
  input  logic               si_i,
  input  logic               hold_ni,
  input  logic [1:0]         addr_i,
  input  logic               wip_i,
  input  logic [NPOT*DW-1:0] wcr_i,
  input  logic [NPOT*DW-1:0] dr_rdata_i,
  output logic               so_o,
  output logic               so_oe_o,
  output logic [NPOT-1:0]    wcr_we_o,
  output logic [NPOT*DW-1:0] wcr_wdata_o,
  output logic [NPOT-1:0]    wcr_step_o,
  output logic               wcr_up_o,
  output logic [NPOT-1:0]    dr_we_o,
  output logic [RSEL_W-1:0]  dr_sel_o,
  output logic [NPOT*DW-1:0] dr_wdata_o
);
  logic              start, active, rise, bit_s, byte_vld, tx_load, tx_en;
  logic [BYTE_W-1:0] byte_s, tx_byte;

  assign so_oe_o = !cs_ni;

  dpot_spi_phy u_phy (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sck_i      (sck_i),
    .cs_ni      (cs_ni),
    .si_i       (si_i),
    .hold_ni    (hold_ni),
    .tx_load_i  (tx_load),
    .tx_byte_i  (tx_byte),
    .tx_en_i    (tx_en),
    .start_o    (start),
    .active_o   (active),
    .rise_o     (rise),
    .bit_o      (bit_s),
    .byte_vld_o (byte_vld),
    .byte_o     (byte_s),
    .so_o       (so_o)
  );

  dpot_cmd_fsm #(.DW(DW), .TYPE_ID(TYPE_ID)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .active_i    (active),
    .rise_i      (rise),
    .bit_i       (bit_s),
    .byte_vld_i  (byte_vld),
    .byte_i      (byte_s),
    .addr_i      (addr_i),
    .wip_i       (wip_i),
    .wcr_i       (wcr_i),
    .dr_rdata_i  (dr_rdata_i),
    .tx_load_o   (tx_load),
    .tx_byte_o   (tx_byte),
    .tx_en_o     (tx_en),
    .wcr_we_o    (wcr_we_o),
    .wcr_wdata_o (wcr_wdata_o),
    .wcr_step_o  (wcr_step_o),
    .wcr_up_o    (wcr_up_o),
    .dr_we_o     (dr_we_o),
    .dr_sel_o    (dr_sel_o),
    .dr_wdata_o  (dr_wdata_o)
  );
endmodule

// File: rtl/dpot_spi_decoder_chk.sv
module dpot_spi_decoder_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_ni,
  input logic       sck_i,
  input logic       so_o,
  input logic [1:0] wcr_we_o,
  input logic [1:0] wcr_step_o,
  input logic [1:0] dr_we_o
);
  // R1
  so_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && !$fell(sck_i)) |=> $stable(so_o));

  // R12
  quiet_desel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cs_ni) |-> (wcr_we_o == 2'b00 && wcr_step_o == 2'b00 && dr_we_o == 2'b00));

  // R12
  one_kind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({|wcr_we_o, |wcr_step_o, |dr_we_o}));

  // R12
  wcr_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|wcr_we_o) |=> (wcr_we_o == 2'b00));

  // R12
  dr_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|dr_we_o) |=> (dr_we_o == 2'b00));

  // R9
  step_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wcr_step_o));
endmodule

bind dpot_spi_decoder dpot_spi_decoder_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_ni      (cs_ni),
  .sck_i      (sck_i),
  .so_o       (so_o),
  .wcr_we_o   (wcr_we_o),
  .wcr_step_o (wcr_step_o),
  .dr_we_o    (dr_we_o)
);

// File: tb/dpot_spi_decoder_tb.sv
module dpot_spi_decoder_tb;
  localparam int DW  = 6;
  localparam int EVW = 9 + 4*DW;
  typedef logic [EVW-1:0] ev_t;

  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b0, si = 1'b0, hold_n = 1'b1, wip = 1'b0;
  logic [1:0] addr = 2'b10;
  logic so, so_oe, up;
  logic [1:0] wwe, stp, dwe, dsel;
  logic [2*DW-1:0] wdat, ddat, wcr_bus, dr_bus;

  logic [DW-1:0] m_wcr [2] = '{6'h20, 6'h20};
  logic [DW-1:0] m_dr [2][4] = '{'{6'h01, 6'h04, 6'h07, 6'h0A}, '{6'h31, 6'h34, 6'h37, 6'h3A}};

  int checks = 0, errors = 0;
  ev_t exp_q[$];
  string tag_q[$];
  ev_t ev_m, ev_e;
  string tg;

  always #4 clk = ~clk;

  assign wcr_bus = {m_wcr[1], m_wcr[0]};
  assign dr_bus  = {m_dr[1][dsel], m_dr[0][dsel]};

  dpot_spi_decoder #(.DW(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs_n), .si_i(si), .hold_ni(hold_n),
    .addr_i(addr), .wip_i(wip), .wcr_i(wcr_bus), .dr_rdata_i(dr_bus),
    .so_o(so), .so_oe_o(so_oe), .wcr_we_o(wwe), .wcr_wdata_o(wdat), .wcr_step_o(stp),
    .wcr_up_o(up), .dr_we_o(dwe), .dr_sel_o(dsel), .dr_wdata_o(ddat)
  );

  function automatic ev_t mk_ev(input logic [1:0] we, input logic [1:0] st, input logic u,
                                input logic [1:0] de, input logic [1:0] sl,
                                input logic [2*DW-1:0] wd, input logic [2*DW-1:0] dd);
    logic [DW-1:0] w1, w0, d1, d0;
    w0 = we[0] ? wd[DW-1:0] : '0;
    w1 = we[1] ? wd[2*DW-1:DW] : '0;
    d0 = de[0] ? dd[DW-1:0] : '0;
    d1 = de[1] ? dd[2*DW-1:DW] : '0;
    return {we, st, (|st) ? u : 1'b0, de, (|de) ? sl : 2'b00, w1, w0, d1, d0};
  endfunction

  task automatic expect_ev(input ev_t e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  // Event monitor and neighbour register model, sampled mid-cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (so_oe !== !cs_n) begin
        errors++;
        $display("FAIL R1 so_oe act=%b exp=%b", so_oe, !cs_n);
      end
      if (|{wwe, stp, dwe}) begin
        ev_m = mk_ev(wwe, stp, up, dwe, dsel, wdat, ddat);
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R12 unexpected strobe act=%h exp=none", ev_m);
        end else begin
          ev_e = exp_q.pop_front();
          tg   = tag_q.pop_front();
          if (ev_m !== ev_e) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tg, ev_m, ev_e);
          end
        end
        for (int p = 0; p < 2; p++) begin
          if (wwe[p]) m_wcr[p] = wdat[p*DW +: DW];
          if (dwe[p]) m_dr[p][dsel] = ddat[p*DW +: DW];
          if (stp[p]) begin
            if (up && m_wcr[p] != '1) m_wcr[p] = m_wcr[p] + 1'b1;
            else if (!up && m_wcr[p] != '0) m_wcr[p] = m_wcr[p] - 1'b1;
          end
        end
      end
    end
  end

  task automatic chk(input string t, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", t, act, exp);
    end
  endtask

  task automatic pause_here();
    hold_n = 1'b0;
    repeat (3) @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      sck = 1'b1; si = ~si;
      repeat (3) @(negedge clk);
      sck = 1'b0;
      repeat (3) @(negedge clk);
    end
    hold_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic bit_x(input logic b, output logic r);
    si = b;
    repeat (4) @(negedge clk);
    r = so;
    sck = 1'b1;
    repeat (4) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic byte_x(input logic [7:0] t, input int hold_at, output logic [7:0] r);
    logic b;
    r = '0;
    for (int i = 7; i >= 0; i--) begin
      if (i == hold_at) pause_here();
      bit_x(t[i], b);
      r = {r[6:0], b};
    end
  endtask

  task automatic begin_txn();
    @(negedge clk);
    cs_n = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic end_txn(input string t);
    repeat (3) @(negedge clk);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL %s missing strobes act=%0d exp=0", t, exp_q.size());
      exp_q.delete();
      tag_q.delete();
    end
  endtask

  function automatic logic [7:0] id_b(input logic [1:0] a);
    return {4'b0101, 2'b00, a};
  endfunction

  function automatic logic [7:0] ins(input logic [3:0] op, input logic [1:0] r, input logic p);
    return {op, r, 1'b0, p};
  endfunction

  task automatic cmd3(input logic [7:0] i0, input logic [7:0] i1, input logic [7:0] d,
                      input int hold_at, output logic [7:0] r);
    logic [7:0] junk;
    begin_txn();
    byte_x(i0, -1, junk);
    byte_x(i1, -1, junk);
    byte_x(d, hold_at, r);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=running exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rx, junk;
    repeat (5) @(negedge clk);
    checks++;
    if (so !== 1'b0 || wwe !== 2'b00 || stp !== 2'b00 || dwe !== 2'b00) begin
      errors++;
      $display("FAIL reset state act=%b%b%b%b exp=0", so, wwe, stp, dwe);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R3: select already low at reset release, no edge seen, so nothing decodes
    byte_x(id_b(addr), -1, junk);
    byte_x(ins(4'hA, 2'd0, 1'b0), -1, junk);
    byte_x(8'h11, -1, junk);
    end_txn("R3");
    chk("R1 so_oe deselected", {7'b0, so_oe}, 8'h00);

    // R7 R4: write wiper pot 0
    expect_ev(mk_ev(2'b01, 2'b00, 1'b0, 2'b00, 2'b00, {2{6'h15}}, '0), "R7 write wcr");
    cmd3(id_b(addr), ins(4'hA, 2'd0, 1'b0), 8'hD5, -1, rx);
    end_txn("R7 write wcr");

    // R7 R4: write data register pot 1 index 2
    expect_ev(mk_ev(2'b00, 2'b00, 1'b0, 2'b10, 2'd2, '0, {2{6'h2A}}), "R7 write dr");
    cmd3(id_b(addr), ins(4'hC, 2'd2, 1'b1), 8'h2A, -1, rx);
    end_txn("R7 write dr");

    // R8 reads
    cmd3(id_b(addr), ins(4'hB, 2'd2, 1'b1), 8'h00, -1, rx);
    end_txn("R8 read dr");
    chk("R8 read dr", rx, 8'h2A);
    cmd3(id_b(addr), ins(4'h9, 2'd0, 1'b0), 8'h00, -1, rx);
    end_txn("R8 read wcr");
    chk("R8 read wcr", rx, 8'h15);
    wip = 1'b1;
    cmd3(id_b(addr), ins(4'h5, 2'd0, 1'b0), 8'h00, -1, rx);
    end_txn("R8 status");
    chk("R8 status busy", rx, 8'h01);
    wip = 1'b0;
    cmd3(id_b(addr), ins(4'h5, 2'd0, 1'b0), 8'h00, -1, rx);
    end_txn("R8 status");
    chk("R8 status idle", rx, 8'h00);
    cmd3(id_b(addr), ins(4'hB, 2'd3, 1'b0), 8'h00, -1, rx);
    end_txn("R8 read dr");
    chk("R8 read dr pot0 idx3", rx, {2'b00, m_dr[0][3]});

    // R5 single transfers
    expect_ev(mk_ev(2'b10, 2'b00, 1'b0, 2'b00, 2'b00, {m_dr[1][2], m_dr[0][2]}, '0), "R5 dr to wcr");
    begin_txn();
    byte_x(id_b(addr), -1, junk);
    byte_x(ins(4'h8, 2'd2, 1'b1), -1, junk);
    end_txn("R5 dr to wcr");
    expect_ev(mk_ev(2'b00, 2'b00, 1'b0, 2'b01, 2'd3, '0, {m_wcr[1], m_wcr[0]}), "R5 wcr to dr");
    begin_txn();
    byte_x(id_b(addr), -1, junk);
    byte_x(ins(4'h6, 2'd3, 1'b0), -1, junk);
    end_txn("R5 wcr to dr");
    cmd3(id_b(addr), ins(4'hB, 2'd3, 1'b0), 8'h00, -1, rx);
    end_txn("R5 readback");
    chk("R5 readback", rx, 8'h15);

    // R6 global transfers
    expect_ev(mk_ev(2'b00, 2'b00, 1'b0, 2'b11, 2'd1, '0, {m_wcr[1], m_wcr[0]}), "R6 global store");
    begin_txn();
    byte_x(id_b(addr), -1, junk);
    byte_x(ins(4'h2, 2'd1, 1'b0), -1, junk);
    end_txn("R6 global store");
    expect_ev(mk_ev(2'b11, 2'b00, 1'b0, 2'b00, 2'b00, {m_dr[1][0], m_dr[0][0]}, '0), "R6 global load");
    begin_txn();
    byte_x(id_b(addr), -1, junk);
    byte_x(ins(4'h1, 2'd0, 1'b1), -1, junk);
    end_txn("R6 global load");

    // R2 identification mismatches
    cmd3(id_b(2'b01), ins(4'hA, 2'd0, 1'b0), 8'h3F, -1, rx);
    end_txn("R2 wrong address");
    cmd3({4'b0110, 2'b00, addr}, ins(4'hA, 2'd0, 1'b0), 8'h3F, -1, rx);
    end_txn("R2 wrong type");
    cmd3({4'b0101, 2'b01, addr}, ins(4'hA, 2'd0, 1'b0), 8'h3F, -1, rx);
    end_txn("R2 reserved bits");
    cmd3(id_b(addr), ins(4'h9, 2'd0, 1'b0), 8'h00, -1, rx);
    end_txn("R2 readback");
    chk("R2 wiper untouched", rx, {2'b00, m_dr[0][0]});

    // R11 unknown opcodes
    cmd3(id_b(addr), ins(4'h7, 2'd1, 1'b0), 8'h3F, -1, rx);
    end_txn("R11 op 7");
    cmd3(id_b(addr), ins(4'hF, 2'd1, 1'b1), 8'h3F, -1, rx);
    end_txn("R11 op F");
    cmd3(id_b(addr), ins(4'h0, 2'd0, 1'b0), 8'h3F, -1, rx);
    end_txn("R11 op 0");

    // R9 stepping on pot 1
    begin_txn();
    byte_x(id_b(addr), -1, junk);
    byte_x(ins(4'h3, 2'd0, 1'b1), -1, junk);
    for (int k = 0; k < 5; k++) begin
      logic d, r;
      d = (k != 2 && k != 4);
      expect_ev(mk_ev(2'b00, 2'b10, d, 2'b00, 2'b00, '0, '0), "R9 step");
      bit_x(d, r);
    end
    end_txn("R9 step");

    // R10 pause mid data byte
    expect_ev(mk_ev(2'b10, 2'b00, 1'b0, 2'b00, 2'b00, {2{6'h2C}}, '0), "R10 hold");
    cmd3(id_b(addr), ins(4'hA, 2'd0, 1'b1), 8'h2C, 3, rx);
    end_txn("R10 hold");
    cmd3(id_b(addr), ins(4'h9, 2'd0, 1'b1), 8'h00, 5, rx);
    end_txn("R10 hold read");
    chk("R10 read across pause", rx, 8'h2C);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule